// File: doc/BRIEF.md
# Two-word message mailbox

This block passes messages between a host bus and a processing core. Each message is a pair of 32-bit words. The host writes to one data address to fill an inbound queue, which the core drains. The core fills an outbound queue, which the host drains by reading that same address. The direction therefore follows from the access type alone. Each queue holds `DEPTH` words. The default of two is exactly one message.

Alongside the data address the host sees three more registers:

- **Status word.** It packs the not-empty and not-full flags of both queues next to four sticky interrupt flags.
- **Control word.** It holds the per-queue write enables and the interrupt enables.
- **Pending-bit register.** The core sets its bits, and the host clears them by writing ones.

A single interrupt line reports whether any interrupt flag is set. The host is expected to send a message only when the inbound queue is empty, and to poll the status word before each data access.

Register addresses on `host_addr`: 0 data, 1 status, 2 control, 3 pending bits. Host reads are combinational and valid in the same cycle as `host_en`. All side effects (pops, pushes, clears) take place at the next rising clock edge.

Top module: `msg_mailbox`

## Requirements
- R1: After reset the status word reads 0x0006_0000, the control word reads 0x0300_0000, `irq` is 0, `core_in_valid` is 0 and `core_out_ready` is 1.
- R2: A host write to address 0, while control bit 25 is set, appends `host_wdata` to the inbound queue. The core sees the words in write order on `core_in_data` while `core_in_valid` is high, and `core_in_pop` removes the head.
- R3: A `core_out_push` while control bit 24 is set appends `core_out_data` to the outbound queue. Each host read of address 0 returns the oldest word and removes it.
- R4: Status bit 16 means the outbound queue is not empty, bit 17 the inbound queue is not full, bit 18 the outbound queue is not full, and bit 19 the inbound queue is not empty. With `DEPTH` 2, two words fill a queue.
- R5: A push into a full queue is dropped, and the queue contents and order are kept.
- R6: A host read of address 0 with the outbound queue empty returns 0 and changes nothing. A `core_in_pop` with the inbound queue empty is ignored.
- R7: With control bit 25 clear, host data writes are dropped. With control bit 24 clear, core pushes are dropped.
- R8: Pending bits [15:0] at address 3 are set by `core_mbox_set` and cleared by a host write of ones to the same bit positions. Writing 0x0000_F0F0 clears bits 4-7 and 12-15 and leaves the others.
- R9: There are four sticky interrupt flags:
  - Status bit 20 is set while any pending bit is set and control bit 20 is on.
  - Status bit 21 is set while the inbound queue is empty and control bit 17 is on.
  - Status bit 22 is set while the outbound queue is full and control bit 16 is on.
  - Status bit 23 is set on a `core_watch` pulse while control bit 23 is on.

  A host write of ones to status bits 20-23 clears those flags. A flag whose condition still holds stays set.
- R10: `irq` is high exactly when at least one of status bits 20-23 is set.
- R11: Only control bits 16, 17, 20, 23, 24 and 25 are stored. Writing all ones reads back 0x0393_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 pending bits |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| core_in_pop | input | 1 | Core removes the inbound head word |
| core_in_valid | output | 1 | Inbound queue holds a word |
| core_in_data | output | 32 | Inbound head word, zero when empty |
| core_out_push | input | 1 | Core appends a word to the outbound queue |
| core_out_data | input | 32 | Word to append |
| core_out_ready | output | 1 | Outbound queue has room |
| core_mbox_set | input | 16 | Pending bits to set |
| core_watch | input | 1 | Watch event pulse |
| irq | output | 1 | OR of the four interrupt flags |

## Verification
The bench goes after the following corner cases:

- **Third word into a full queue.** A design that overwrote on full would hand the core an extra or out-of-order word, and the scoreboard would catch it.
- **Read of an empty outbound queue.** A design that returned stale data would fail the zero check.
- **Pop of an empty inbound queue.** A design that let this corrupt the pointers would deliver the next real word wrongly.
- **Write-one clear while the condition persists.** A design that let the clear win would drop an interrupt that is still pending.
- **Partial clear of the pending bits.** A design with the wrong mask would clear the wrong half of the register.
- **Write-enable bits.** A design that ignored them would let traffic into a disabled queue.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_MBOX = 2'd3
  } mbx_reg_e;

  // status word bit positions
  localparam int ST_OUT_NE  = 16;
  localparam int ST_IN_NF   = 17;
  localparam int ST_OUT_NF  = 18;
  localparam int ST_IN_NE   = 19;
  localparam int ST_FLAG_LO = 20;

  // control word bit positions
  localparam int CT_OUT_IE = 16;
  localparam int CT_IN_IE  = 17;
  localparam int CT_MB_IE  = 20;
  localparam int CT_WD_IE  = 23;
  localparam int CT_OUT_WE = 24;
  localparam int CT_IN_WE  = 25;

  localparam logic [REG_W-1:0] CTL_MASK  = 32'h0393_0000;
  localparam logic [REG_W-1:0] CTL_RESET = 32'h0300_0000;

  // interrupt flag index inside the four-bit flag group
  localparam int NFLAG  = 4;
  localparam int FL_MB  = 0;
  localparam int FL_IN  = 1;
  localparam int FL_OUT = 2;
  localparam int FL_WD  = 3;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) begin
      return '0;
    end
    return p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) begin
      wr_ptr_d = ptr_inc(wr_ptr_q);
    end
    if (do_pop) begin
      rd_ptr_d = ptr_inc(rd_ptr_q);
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (do_push || do_pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_ptr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        mem[i] <= push_data;
      end
    end
  end

  assign head  = empty ? '0 : mem[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/mbx_pending.sv
module mbx_pending #(
  parameter int MBW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MBW-1:0] set_bits,
  input  logic           clr_en,
  input  logic [MBW-1:0] clr_bits,
  output logic [MBW-1:0] pend
);

  logic [MBW-1:0] pend_q, pend_d;
  logic [MBW-1:0] clr_mask;
  logic           upd;

  assign clr_mask = clr_en ? clr_bits : '0;
  assign upd      = clr_en || (set_bits != '0);

  always_comb begin
    pend_d = (pend_q & ~clr_mask) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cond,
  input  logic [NF-1:0] enable,
  input  logic          clr_en,
  input  logic [NF-1:0] clr_bits,
  output logic [NF-1:0] flags,
  output logic          irq
);

  logic [NF-1:0] flag_q, flag_d;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_comb begin
      flag_d[k] = flag_q[k];
      if (clr_en && clr_bits[k]) begin
        flag_d[k] = 1'b0;
      end
      if (cond[k] && enable[k]) begin
        flag_d[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;
  assign irq   = |flag_q;

endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int MBW   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             core_in_pop,
  output logic             core_in_valid,
  output logic [REG_W-1:0] core_in_data,
  input  logic             core_out_push,
  input  logic [REG_W-1:0] core_out_data,
  output logic             core_out_ready,
  input  logic [MBW-1:0]   core_mbox_set,
  input  logic             core_watch,
  output logic             irq
);

  logic             rst_q;
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic             ctl_wr, stat_wr, mbox_wr, data_wr, data_rd;
  logic             in_push, out_push;
  logic [REG_W-1:0] out_head;
  logic [CW-1:0]    in_cnt, out_cnt;
  logic             in_full, in_empty, out_full, out_empty;
  logic [MBW-1:0]   mbox_pend;
  logic [NFLAG-1:0] irq_cond, irq_en, irq_flags;
  logic [REG_W-1:0] stat_word;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q  (rst_q)
  );

  // host access decode
  assign data_wr = host_en &&  host_we && (host_addr == REG_DATA);
  assign data_rd = host_en && !host_we && (host_addr == REG_DATA);
  assign stat_wr = host_en &&  host_we && (host_addr == REG_STAT);
  assign ctl_wr  = host_en &&  host_we && (host_addr == REG_CTRL);
  assign mbox_wr = host_en &&  host_we && (host_addr == REG_MBOX);

  assign in_push  = data_wr && ctl_q[CT_IN_WE];
  assign out_push = core_out_push && ctl_q[CT_OUT_WE];

  // control register
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d = host_wdata & CTL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctl_q <= CTL_RESET;
    end else if (ctl_wr) begin
      ctl_q <= ctl_d;
    end
  end

  // host to core queue
  mbx_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_in_q (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (in_push),
    .push_data (host_wdata),
    .pop       (core_in_pop),
    .head      (core_in_data),
    .count     (in_cnt),
    .full      (in_full),
    .empty     (in_empty)
  );

  // core to host queue
  mbx_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_out_q (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (out_push),
    .push_data (core_out_data),
    .pop       (data_rd),
    .head      (out_head),
    .count     (out_cnt),
    .full      (out_full),
    .empty     (out_empty)
  );

  assign core_in_valid  = !in_empty;
  assign core_out_ready = !out_full;

  mbx_pending #(.MBW(MBW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_q),
    .set_bits (core_mbox_set),
    .clr_en   (mbox_wr),
    .clr_bits (host_wdata[MBW-1:0]),
    .pend     (mbox_pend)
  );

  // interrupt conditions and enables
  always_comb begin
    irq_cond         = '0;
    irq_cond[FL_MB]  = (mbox_pend != '0);
    irq_cond[FL_IN]  = in_empty;
    irq_cond[FL_OUT] = out_full;
    irq_cond[FL_WD]  = core_watch;
    irq_en           = '0;
    irq_en[FL_MB]    = ctl_q[CT_MB_IE];
    irq_en[FL_IN]    = ctl_q[CT_IN_IE];
    irq_en[FL_OUT]   = ctl_q[CT_OUT_IE];
    irq_en[FL_WD]    = ctl_q[CT_WD_IE];
  end

  mbx_irq_flags #(.NF(NFLAG)) u_irq (
    .clk      (clk),
    .rst_n    (rst_q),
    .cond     (irq_cond),
    .enable   (irq_en),
    .clr_en   (stat_wr),
    .clr_bits (host_wdata[ST_FLAG_LO +: NFLAG]),
    .flags    (irq_flags),
    .irq      (irq)
  );

  // status word
  always_comb begin
    stat_word                          = '0;
    stat_word[ST_OUT_NE]               = !out_empty;
    stat_word[ST_IN_NF]                = !in_full;
    stat_word[ST_OUT_NF]               = !out_full;
    stat_word[ST_IN_NE]                = !in_empty;
    stat_word[ST_FLAG_LO +: NFLAG]     = irq_flags;
  end

  // read mux
  always_comb begin
    case (host_addr)
      REG_DATA: host_rdata = out_head;
      REG_STAT: host_rdata = stat_word;
      REG_CTRL: host_rdata = ctl_q;
      default:  host_rdata = REG_W'(mbox_pend);
    endcase
  end

endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk #(
  parameter int DEPTH = 2,
  parameter int MBW   = 16,
  parameter int CW    = 2
) (
  input logic           clk,
  input logic           rst_q,
  input logic           host_en,
  input logic           host_we,
  input logic [1:0]     host_addr,
  input logic [31:0]    host_wdata,
  input logic [31:0]    host_rdata,
  input logic           core_in_pop,
  input logic           core_mbox_set_any,
  input logic [MBW-1:0] mbox_pend,
  input logic [CW-1:0]  in_cnt,
  input logic [CW-1:0]  out_cnt,
  input logic           irq
);

  logic host_data_wr;
  assign host_data_wr = host_en && host_we && (host_addr == 2'd0);

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));

  // R5
  in_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_data_wr && (in_cnt == CW'(DEPTH)) && !core_in_pop) |=> (in_cnt == CW'(DEPTH)));

  // R6
  in_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (core_in_pop && (in_cnt == '0) && !host_data_wr) |=> (in_cnt == '0));

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_en && !host_we && (host_addr == 2'd0) && (out_cnt == '0)) |-> (host_rdata == '0));

  // R8
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_en && host_we && (host_addr == 2'd3) && !core_mbox_set_any)
      |=> ((mbox_pend & $past(host_wdata[MBW-1:0])) == '0));

  // R10
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_en && !host_we && (host_addr == 2'd1)) |-> (irq == (host_rdata[23:20] != 4'd0)));

endmodule

bind msg_mailbox msg_mailbox_chk #(.DEPTH(DEPTH), .MBW(MBW), .CW(CW)) u_chk (
  .clk               (clk),
  .rst_q             (rst_q),
  .host_en           (host_en),
  .host_we           (host_we),
  .host_addr         (host_addr),
  .host_wdata        (host_wdata),
  .host_rdata        (host_rdata),
  .core_in_pop       (core_in_pop),
  .core_mbox_set_any (|core_mbox_set),
  .mbox_pend         (mbox_pend),
  .in_cnt            (in_cnt),
  .out_cnt           (out_cnt),
  .irq               (irq)
);

// File: tb/sim_msg_mailbox.sv
module sim_msg_mailbox;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_en, host_we;
  logic [1:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        core_in_pop, core_in_valid;
  logic [31:0] core_in_data;
  logic        core_out_push, core_out_ready;
  logic [31:0] core_out_data;
  logic [15:0] core_mbox_set;
  logic        core_watch;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_in[$];
  logic [31:0] exp_out[$];
  logic drain_in  = 1'b0;
  logic force_pop = 1'b0;
  logic done      = 1'b0;

  always #2.5 clk = ~clk;

  msg_mailbox u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_en        (host_en),
    .host_we        (host_we),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_rdata     (host_rdata),
    .core_in_pop    (core_in_pop),
    .core_in_valid  (core_in_valid),
    .core_in_data   (core_in_data),
    .core_out_push  (core_out_push),
    .core_out_data  (core_out_data),
    .core_out_ready (core_out_ready),
    .core_mbox_set  (core_mbox_set),
    .core_watch     (core_watch),
    .irq            (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_en = 1'b0;
  endtask

  // driver for the host side of the inbound queue: pushes the expected word
  task automatic send_in(input logic [31:0] d, input bit accepted);
    if (accepted) exp_in.push_back(d);
    host_wr(2'd0, d);
  endtask

  task automatic core_push(input logic [31:0] d, input bit accepted);
    if (accepted) exp_out.push_back(d);
    @(negedge clk);
    core_out_push = 1'b1; core_out_data = d;
    @(negedge clk);
    core_out_push = 1'b0;
  endtask

  task automatic recv_out(input string tag);
    logic [31:0] d;
    logic [31:0] e;
    e = (exp_out.size() > 0) ? exp_out.pop_front() : 32'h0;
    host_rd(2'd0, d);
    chk(tag, d, e);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] e);
    logic [31:0] d;
    host_rd(a, d);
    chk(tag, d, e);
  endtask

  // monitor: pops inbound words on the core side and compares with the scoreboard
  initial begin
    core_in_pop = 1'b0;
    forever begin
      @(negedge clk);
      if (drain_in && core_in_valid) begin
        if (exp_in.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 unexpected inbound word actual=0x%08h expected=none", core_in_data);
        end else begin
          chk("R2 inbound order", core_in_data, exp_in.pop_front());
        end
        core_in_pop = 1'b1;
      end else begin
        core_in_pop = force_pop;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_en = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_wdata = '0;
    core_out_push = 1'b0; core_out_data = '0; core_mbox_set = '0; core_watch = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd_chk("R1 status", 2'd1, 32'h0006_0000);
    rd_chk("R1 control", 2'd2, 32'h0300_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 in_valid", {31'd0, core_in_valid}, 32'd0);
    chk("R1 out_ready", {31'd0, core_out_ready}, 32'd1);

    // R6 empty read returns zero and changes nothing
    rd_chk("R6 empty read", 2'd0, 32'h0);
    rd_chk("R6 status after empty read", 2'd1, 32'h0006_0000);

    // R11 writable control bits
    host_wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R11 control mask", 2'd2, 32'h0393_0000);
    host_wr(2'd2, 32'h0300_0000);
    host_wr(2'd1, 32'h00F0_0000);
    rd_chk("R11 status restored", 2'd1, 32'h0006_0000);

    // R2 R4 R5 inbound fill and overflow
    send_in(32'hA1A1_0001, 1'b1);
    send_in(32'hA1A1_0002, 1'b1);
    rd_chk("R4 inbound full status", 2'd1, 32'h000C_0000);
    send_in(32'hDEAD_0003, 1'b0);
    rd_chk("R5 inbound still full", 2'd1, 32'h000C_0000);
    drain_in = 1'b1;
    idle(4);
    chk("R2 all inbound consumed", exp_in.size(), 32'd0);
    chk("R2 in_valid low", {31'd0, core_in_valid}, 32'd0);
    drain_in = 1'b0;
    rd_chk("R4 inbound empty status", 2'd1, 32'h0006_0000);

    // R6 core pop on empty is ignored
    force_pop = 1'b1;
    idle(2);
    force_pop = 1'b0;
    idle(1);
    send_in(32'hB2B2_0004, 1'b1);
    chk("R6 word after empty pop", core_in_data, 32'hB2B2_0004);
    drain_in = 1'b1;
    idle(3);
    drain_in = 1'b0;

    // R3 R4 R5 outbound
    core_push(32'hC3C3_0001, 1'b1);
    core_push(32'hC3C3_0002, 1'b1);
    chk("R4 out_ready full", {31'd0, core_out_ready}, 32'd0);
    core_push(32'hDEAD_0005, 1'b0);
    rd_chk("R4 outbound full status", 2'd1, 32'h0003_0000);
    recv_out("R3 outbound word 1");
    recv_out("R3 outbound word 2");
    rd_chk("R6 outbound drained read", 2'd0, 32'h0);
    rd_chk("R5 outbound empty status", 2'd1, 32'h0006_0000);

    // R7 write enables cleared
    host_wr(2'd2, 32'h0000_0000);
    send_in(32'h7777_0001, 1'b0);
    core_push(32'h7777_0002, 1'b0);
    rd_chk("R7 both queues untouched", 2'd1, 32'h0006_0000);
    chk("R7 in_valid low", {31'd0, core_in_valid}, 32'd0);
    host_wr(2'd2, 32'h0300_0000);

    // R8 pending bits
    @(negedge clk) core_mbox_set = 16'hFFFF;
    @(negedge clk) core_mbox_set = 16'h0000;
    rd_chk("R8 pending set", 2'd3, 32'h0000_FFFF);
    host_wr(2'd3, 32'h0000_F0F0);
    rd_chk("R8 clear F0F0", 2'd3, 32'h0000_0F0F);
    host_wr(2'd3, 32'h0000_000F);
    rd_chk("R8 clear low nibble", 2'd3, 32'h0000_0F00);

    // R9 R10 inbound-empty flag, clear while condition holds
    host_wr(2'd2, 32'h0302_0000);
    idle(1);
    rd_chk("R9 inbound flag set", 2'd1, 32'h0026_0000);
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    host_wr(2'd1, 32'h0020_0000);
    idle(1);
    rd_chk("R9 flag kept while empty", 2'd1, 32'h0026_0000);
    send_in(32'hE5E5_0001, 1'b1);
    host_wr(2'd1, 32'h0020_0000);
    idle(1);
    rd_chk("R9 flag cleared", 2'd1, 32'h000E_0000);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    host_wr(2'd2, 32'h0300_0000);
    drain_in = 1'b1;
    idle(3);
    drain_in = 1'b0;
    host_wr(2'd1, 32'h00F0_0000);

    // R9 watch flag
    host_wr(2'd2, 32'h0380_0000);
    @(negedge clk) core_watch = 1'b1;
    @(negedge clk) core_watch = 1'b0;
    idle(1);
    rd_chk("R9 watch flag", 2'd1, 32'h0086_0000);
    chk("R10 irq from watch", {31'd0, irq}, 32'd1);
    host_wr(2'd1, 32'h0080_0000);
    idle(1);
    rd_chk("R9 watch cleared", 2'd1, 32'h0006_0000);

    // R9 outbound full flag
    host_wr(2'd2, 32'h0301_0000);
    core_push(32'hF6F6_0001, 1'b1);
    core_push(32'hF6F6_0002, 1'b1);
    idle(1);
    rd_chk("R9 outbound flag", 2'd1, 32'h0043_0000);
    chk("R10 irq from outbound", {31'd0, irq}, 32'd1);
    recv_out("R3 flagged word 1");
    host_wr(2'd1, 32'h0040_0000);
    idle(1);
    rd_chk("R9 outbound flag cleared", 2'd1, 32'h0007_0000);
    recv_out("R3 flagged word 2");

    // R9 pending-bit flag
    host_wr(2'd2, 32'h0310_0000);
    idle(1);
    rd_chk("R9 pending flag", 2'd1, 32'h0016_0000);
    chk("R10 irq from pending", {31'd0, irq}, 32'd1);
    host_wr(2'd3, 32'h0000_FFFF);
    host_wr(2'd1, 32'h0010_0000);
    idle(1);
    rd_chk("R9 pending flag cleared", 2'd1, 32'h0006_0000);
    chk("R10 irq final", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule